// File: doc/BRIEF.md
# Decimal Keypad Priority Encoder

This block turns a row of ten decimal key lines into a four-bit BCD digit. Each key line is active-low: pulling a line low means that key is pressed. Lines 1 through 9 take part in the encoding. When several of them are low together, the highest-numbered one wins. The digit code leaves the block complemented on active-low outputs. When none of lines 1 to 9 is pressed, the outputs show the complement of zero, which is all ones.

Key 0 has a line but no code of its own, because its digit is the same as the idle code. The wrapper adds a key-hit flag that goes high whenever any of the ten lines is low, key 0 included. Logic downstream can use that flag to tell "key 0 pressed" apart from "nothing pressed".

The path is purely combinational, with no register or handshake at either edge. The outputs follow the key lines within the same cycle, so there is no back-pressure to manage.

Top module: `dec_prio_keypad`

## Requirements
- R1: Bit k of `key_n_i` is the line for decimal digit k, and it counts as pressed when it is 0.
- R2: When exactly one of lines 1..9 is pressed, at digit d, `bcd_n_o` equals the bitwise complement of the 4-bit binary value of d.
- R3: When several of lines 1..9 are pressed, `bcd_n_o` encodes the highest pressed index. No line above the encoded digit is pressed, and the encoded line itself is pressed.
- R4: When none of lines 1..9 is pressed, `bcd_n_o` is 4'b1111.
- R5: Line 0 has no effect on `bcd_n_o`, whatever the state of lines 1..9.
- R6: `key_hit_o` is 1 exactly when at least one of the ten lines, line 0 included, is 0.
- R7: Pressing digit 3 alone drives `bcd_n_o` to 4'b1100.
- R8: The complement of `bcd_n_o` never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| key_n_i | input | 10 | Active-low decimal key lines; bit k belongs to digit k |
| bcd_n_o | output | 4 | Active-low BCD code of the highest pressed digit among 1..9 |
| key_hit_o | output | 1 | High while any key line is low |

## Verification
The assertions watch, on every input change, four properties of the outputs. The encoded digit stays in the decimal range. The line it names is really pressed, and no higher line is. The idle code appears exactly when lines 1..9 are all released. The hit flag matches the state of all ten lines. The bench's scenarios are needed for what the assertions cannot show on their own. These are the exact code value for each single digit, the specific digit-3 pattern, and the fact that toggling line 0 never moves the code. The bench covers these by sweeping all 1024 line combinations against a reference search.

// File: rtl/dec_prio_pkg.sv
package dec_prio_pkg;
  localparam int unsigned DIGITS = 10;
  localparam int unsigned CODE_W = $clog2(DIGITS);
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dec_prio_pick.sv
// Highest-index search over the active-high requests for digits 1..DIGITS-1.
module dec_prio_pick #(
  parameter int unsigned DIGITS = dec_prio_pkg::DIGITS,
  localparam int unsigned CODE_W = $clog2(DIGITS)
) (
  input  logic [DIGITS-2:0]  req_i,
  output logic [CODE_W-1:0]  code_o
);
  always_comb begin
    code_o = '0;
    for (int i = 0; i < int'(DIGITS) - 1; i++) begin
      if (req_i[i]) code_o = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/dec_prio_drive.sv
// Complements the code bit by bit onto active-low pins.
module dec_prio_drive #(
  parameter int unsigned CODE_W = dec_prio_pkg::CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] pin_n_o
);
  for (genvar b = 0; b < int'(CODE_W); b++) begin : g_bit
    assign pin_n_o[b] = ~code_i[b];
  end
endmodule

// File: rtl/dec_prio_hit.sv
// Flags any low line across the whole keypad row.
module dec_prio_hit #(
  parameter int unsigned DIGITS = dec_prio_pkg::DIGITS
) (
  input  logic [DIGITS-1:0] line_n_i,
  output logic              hit_o
);
  assign hit_o = ~(&line_n_i);
endmodule

// File: rtl/dec_prio_keypad.sv
module dec_prio_keypad #(
  parameter int unsigned DIGITS = dec_prio_pkg::DIGITS,
  localparam int unsigned CODE_W = $clog2(DIGITS)
) (
  input  logic [DIGITS-1:0] key_n_i,
  output logic [CODE_W-1:0] bcd_n_o,
  output logic              key_hit_o
);
  logic [DIGITS-2:0] req;     // active-high presses, digits 1..DIGITS-1 (R1)
  logic [CODE_W-1:0] code;

  assign req = ~key_n_i[DIGITS-1:1];  // line 0 never reaches the encoder (R5)

  dec_prio_pick #(.DIGITS(DIGITS)) u_pick (
    .req_i  (req),
    .code_o (code)
  );

  dec_prio_drive #(.CODE_W(CODE_W)) u_drive (
    .code_i  (code),
    .pin_n_o (bcd_n_o)
  );

  dec_prio_hit #(.DIGITS(DIGITS)) u_hit (
    .line_n_i (key_n_i),
    .hit_o    (key_hit_o)
  );
endmodule

// File: rtl/dec_prio_keypad_chk.sv
module dec_prio_keypad_chk #(
  parameter int unsigned DIGITS = dec_prio_pkg::DIGITS,
  localparam int unsigned CODE_W = $clog2(DIGITS)
) (
  input logic [DIGITS-1:0] key_n_i,
  input logic [CODE_W-1:0] bcd_n_o,
  input logic              key_hit_o
);
  function automatic logic none_above(input logic [DIGITS-1:0] k, input int d);
    logic ok = 1'b1;
    for (int j = 1; j < int'(DIGITS); j++) if (j > d && !k[j]) ok = 1'b0;
    return ok;
  endfunction

  logic [CODE_W-1:0] dig;
  assign dig = ~bcd_n_o;

  always_comb begin
    // R8: code stays decimal
    a_r8_code_range: assert (int'(dig) < int'(DIGITS));
    // R4: idle code exactly when lines 1..9 are released
    a_r4_idle_code: assert ((dig == '0) == (&key_n_i[DIGITS-1:1]));
    // R3: encoded line is pressed and nothing higher is
    if (dig != '0 && int'(dig) < int'(DIGITS)) begin
      a_r3_line_pressed: assert (key_n_i[dig] == 1'b0);
    end
    a_r3_none_above: assert (none_above(key_n_i, int'(dig)));
    // R6: hit flag follows all ten lines
    a_r6_hit_any: assert (key_hit_o == (key_n_i != '1));
  end
endmodule

bind dec_prio_keypad dec_prio_keypad_chk #(.DIGITS(DIGITS)) u_chk (
  .key_n_i   (key_n_i),
  .bcd_n_o   (bcd_n_o),
  .key_hit_o (key_hit_o)
);

// File: tb/dec_prio_keypad_tb.sv
module dec_prio_keypad_tb;
  localparam int DIGITS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIGITS-1:0] key_n = '1;
  logic [3:0] bcd_n;
  logic hit;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dec_prio_keypad u_dut (
    .key_n_i   (key_n),
    .bcd_n_o   (bcd_n),
    .key_hit_o (hit)
  );

  function automatic logic [3:0] ref_code(input logic [DIGITS-1:0] k);
    for (int d = DIGITS - 1; d >= 1; d--) if (!k[d]) return 4'(d);
    return 4'd0;
  endfunction

  task automatic apply(input logic [DIGITS-1:0] k);
    @(negedge clk);
    key_n = k;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [DIGITS-1:0] k);
    logic [3:0] exp_b = ~ref_code(k);
    logic exp_h = (k != '1);
    n_vec++;
    if (bcd_n !== exp_b || hit !== exp_h) begin
      n_bad++;
      $display("FAIL %s keys=%b bcd_n=%b hit=%b expected bcd_n=%b hit=%b",
               req, k, bcd_n, hit, exp_b, exp_h);
    end
  endtask

  task automatic t_idle();   // R4, R6: nothing pressed
    apply('1);
    rst_n = 1'b1;
    check("R4", '1);
  endtask

  task automatic t_single();  // R1, R2: one digit at a time
    for (int d = 1; d < DIGITS; d++) begin
      logic [DIGITS-1:0] k = '1;
      k[d] = 1'b0;
      apply(k);
      check("R2", k);
    end
  endtask

  task automatic t_digit3();  // R7
    apply(10'b11_1111_0111);
    n_vec++;
    if (bcd_n !== 4'b1100) begin
      n_bad++;
      $display("FAIL R7 bcd_n=%b expected 1100", bcd_n);
    end
  endtask

  task automatic t_key0();    // R5, R6: key 0 alone
    apply(10'b11_1111_1110);
    n_vec++;
    if (bcd_n !== 4'b1111 || hit !== 1'b1) begin
      n_bad++;
      $display("FAIL R5 bcd_n=%b hit=%b expected 1111 1", bcd_n, hit);
    end
  endtask

  task automatic t_sweep();   // R3, R5, R6, R8: all 1024 line patterns
    for (int p = 0; p < (1 << DIGITS); p++) begin
      apply(DIGITS'(p));
      check("R3", DIGITS'(p));
      n_vec++;
      if (4'(~bcd_n) > 4'd9) begin
        n_bad++;
        $display("FAIL R8 code=%0d expected <=9", 4'(~bcd_n));
      end
    end
  endtask

  task automatic t_pairs();   // R3: top of two pressed lines wins
    for (int a = 1; a < DIGITS; a++) begin
      for (int b = 1; b < a; b++) begin
        logic [DIGITS-1:0] k = '1;
        k[a] = 1'b0;
        k[b] = 1'b0;
        apply(k);
        n_vec++;
        if (bcd_n !== ~4'(a)) begin
          n_bad++;
          $display("FAIL R3 keys=%b bcd_n=%b expected %b", k, bcd_n, ~4'(a));
        end
      end
    end
  endtask

  initial begin
    t_idle();
    t_single();
    t_digit3();
    t_key0();
    t_pairs();
    t_sweep();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule